// File: doc/BRIEF.md
# Instruction Cache with Critical-Word-First Refill

A small read-only cache sits between a 32-bit instruction fetch port and a memory read port. A fetch that finds its line in the cache completes in the same cycle. A fetch that misses starts a refill of the whole four-word line. The refill is a single wrapping burst that begins at the missed word, and that word goes back to the fetcher in the cycle it arrives. The rest of the line keeps streaming in, and fetches that hit other resident lines are served in the meantime. The whole line is written into the arrays when its last beat arrives.

By default the cache is two-way set-associative with one pseudo-LRU tree bit per set. It can be switched to direct-mapped mode, which uses way 0 only. A mode change is taken only while the cache is disabled, and it starts a full invalidate. The invalidate clears one set per cycle, holds busy the whole time and cannot be interrupted. While the cache is disabled, each fetch is served by a refill and nothing is allocated. A write presented on the fetch port while the cache is enabled is accepted and discarded. It sets a sticky error flag, which drives an interrupt when the interrupt is enabled.

Top module: `icache`

## Requirements
- R1: A read fetch whose line is resident (enabled, not invalidating) gets `f_ready` in the same cycle as `f_req`, with the cached word on `f_rdata`.
- R2: A read miss with no refill active raises `m_req` in the next cycle. `m_addr` is the missed address with bits [1:0] cleared, and both are held until `m_gnt`. Memory then returns 4 beats, one per `m_rvalid`, in wrap order starting at that word.
- R3: The missed word is returned with `f_ready` in the cycle its beat is on `m_rvalid`.
- R4: While a refill is still receiving beats, a fetch that hits another resident line completes with zero wait states.
- R5: A fetch to the line under refill does not issue another `m_req`. It completes when its word has arrived, either from the beat stream or from words already received.
- R6: In two-way mode a refill fills an invalid way if there is one. Otherwise it replaces the way not most recently used, where both hits and fills count as use.
- R7: In direct-mapped mode only way 0 is used, so two lines with the same index (address bits [8:4]) evict each other.
- R8: A write fetch (`f_we`=1) while enabled is accepted in the same cycle, issues no refill, and sets `err_flag` on the next edge. `irq` is `err_flag` and `err_irq_en`, and `err_clear` clears the flag.
- R9: A pulse on `inv_req` holds `inv_busy` high for exactly SETS+1 cycles, during which no read is served. Afterwards every line misses.
- R10: `cfg_direct` (1 = direct-mapped) is taken only while `cfg_enable` is 0, and a change starts a full invalidate. While enabled, changes of `cfg_direct` have no effect.
- R11: While `cfg_enable` is 0, every read misses and is served by a refill that allocates nothing. Lines that were resident before stay valid.
- R12: After reset, `m_req`, `inv_busy`, `err_flag`, `irq` and `f_ready` are 0, and the mode is two-way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Cache enable |
| cfg_direct | input | 1 | 1 selects direct-mapped mode, taken while disabled |
| inv_req | input | 1 | Full invalidate request pulse |
| inv_busy | output | 1 | Invalidate pending or running |
| err_irq_en | input | 1 | Interrupt enable for write errors |
| err_clear | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky write-error flag |
| irq | output | 1 | Error interrupt |
| f_req | input | 1 | Fetch request |
| f_we | input | 1 | Fetch is a write (illegal) |
| f_addr | input | AW | Fetch byte address |
| f_ready | output | 1 | Fetch completes this cycle |
| f_rdata | output | 32 | Fetch data |
| m_req | output | 1 | Refill burst request |
| m_addr | output | AW | Refill start word address |
| m_gnt | input | 1 | Refill request accepted |
| m_rvalid | input | 1 | Refill beat valid |
| m_rdata | input | 32 | Refill beat data |

## Verification
The bench builds the cache with its defaults: 32-bit addresses, four-word lines and 32 sets. Small address constants can then aim three distinct lines at one set, which exercises pseudo-LRU eviction and direct-mapped conflicts. A one-cycle memory latency leaves three beats in flight after the critical word, so a hit can be placed inside an active refill and a second fetch can wait on the tail of the burst. With 32 sets the invalidate window is 33 cycles long, short enough to be counted exactly.

// File: rtl/icache.sv
module icache #(
  parameter int AW = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_direct,
  input  logic          inv_req,
  output logic          inv_busy,
  input  logic          err_irq_en,
  input  logic          err_clear,
  output logic          err_flag,
  output logic          irq,
  input  logic          f_req,
  input  logic          f_we,
  input  logic [AW-1:0] f_addr,
  output logic          f_ready,
  output logic [31:0]   f_rdata,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  input  logic          m_gnt,
  input  logic          m_rvalid,
  input  logic [31:0]   m_rdata
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int LN_W  = AW - 2 - OFF_W;
  localparam int TAG_W = LN_W - IDX_W;

  typedef enum logic [1:0] {IDLE, REQ, DATA} st_t;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [31:0]      dat_q [2][SETS][LINE_WORDS];
  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  plru_q;
  logic             mode_q;
  st_t              st_q;
  logic [LN_W-1:0]  rf_line_q;
  logic [OFF_W-1:0] rf_word_q, rf_cnt_q;
  logic [31:0]      buf_q [LINE_WORDS];
  logic [LINE_WORDS-1:0] bv_q;
  logic             inv_pend_q, inv_run_q, err_q;
  logic [IDX_W-1:0] inv_idx_q;

  wire [TAG_W-1:0] l_tag = f_addr[AW-1 -: TAG_W];
  wire [IDX_W-1:0] l_idx = f_addr[2+OFF_W +: IDX_W];
  wire [OFF_W-1:0] l_off = f_addr[2 +: OFF_W];
  wire [LN_W-1:0]  l_line = f_addr[AW-1 -: LN_W];

  assign inv_busy = inv_pend_q | inv_run_q;
  wire hit0 = vld_q[0][l_idx] && tag_q[0][l_idx] == l_tag;
  wire hit1 = !mode_q && vld_q[1][l_idx] && tag_q[1][l_idx] == l_tag;
  wire hit  = cfg_enable && !inv_busy && (hit0 || hit1);
  wire rd   = f_req && !f_we;
  wire refill_act = st_q != IDLE;
  wire same_line = refill_act && l_line == rf_line_q;
  wire [OFF_W-1:0] beat_word = rf_word_q + rf_cnt_q;
  wire fwd_now = st_q == DATA && m_rvalid && beat_word == l_off;
  wire fwd  = same_line && !inv_busy && (bv_q[l_off] || fwd_now);
  wire start = st_q == IDLE && rd && !hit && !inv_busy;
  wire last  = st_q == DATA && m_rvalid && rf_cnt_q == OFF_W'(LINE_WORDS - 1);

  wire [IDX_W-1:0] f_idx = rf_line_q[IDX_W-1:0];
  wire vic = mode_q ? 1'b0 : !vld_q[0][f_idx] ? 1'b0 : !vld_q[1][f_idx] ? 1'b1 : plru_q[f_idx];

  assign f_ready = f_req && (f_we || hit || fwd);
  assign f_rdata = hit ? (hit1 ? dat_q[1][l_idx][l_off] : dat_q[0][l_idx][l_off])
                 : bv_q[l_off] ? buf_q[l_off] : m_rdata;
  assign m_req  = st_q == REQ;
  assign m_addr = {rf_line_q, rf_word_q, 2'b00};
  assign err_flag = err_q;
  assign irq = err_q & err_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= IDLE;
      rf_line_q <= '0;
      rf_word_q <= '0;
      rf_cnt_q <= '0;
      bv_q <= '0;
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      plru_q <= '0;
      mode_q <= 1'b0;
      inv_pend_q <= 1'b0;
      inv_run_q <= 1'b0;
      inv_idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      case (st_q)
        IDLE: if (start) begin
          st_q <= REQ;
          rf_line_q <= l_line;
          rf_word_q <= l_off;
          rf_cnt_q <= '0;
          bv_q <= '0;
        end
        REQ: if (m_gnt) st_q <= DATA;
        default: if (m_rvalid) begin
          bv_q[beat_word] <= 1'b1;
          rf_cnt_q <= rf_cnt_q + 1'b1;
          if (last) st_q <= IDLE;
        end
      endcase
      if (rd && hit && !mode_q) plru_q[l_idx] <= hit0;
      if (last && cfg_enable) begin
        vld_q[vic][f_idx] <= 1'b1;
        plru_q[f_idx] <= ~vic;
      end
      if (inv_pend_q && st_q == IDLE && !inv_run_q) begin
        inv_pend_q <= 1'b0;
        inv_run_q <= 1'b1;
        inv_idx_q <= '0;
      end
      if (inv_run_q) begin
        vld_q[0][inv_idx_q] <= 1'b0;
        vld_q[1][inv_idx_q] <= 1'b0;
        inv_idx_q <= inv_idx_q + 1'b1;
        if (inv_idx_q == IDX_W'(SETS - 1)) inv_run_q <= 1'b0;
      end
      if (inv_req && !inv_busy) inv_pend_q <= 1'b1;
      if (!cfg_enable && cfg_direct != mode_q) begin
        mode_q <= cfg_direct;
        inv_pend_q <= 1'b1;
      end
      if (err_clear) err_q <= 1'b0;
      if (f_req && f_we && cfg_enable) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == DATA && m_rvalid) buf_q[beat_word] <= m_rdata;
    if (last && cfg_enable) begin
      tag_q[vic][f_idx] <= rf_line_q[LN_W-1 -: TAG_W];
      for (int w = 0; w < LINE_WORDS; w++)
        dat_q[vic][f_idx][w] <= (OFF_W'(w) == beat_word) ? m_rdata : buf_q[w];
    end
  end
endmodule

module icache_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          f_req,
  input logic          f_we,
  input logic          f_ready,
  input logic          hit_any,
  input logic          refill_act,
  input logic          m_req,
  input logic          m_gnt,
  input logic [AW-1:0] m_addr,
  input logic          inv_busy,
  input logic          cfg_enable,
  input logic          mode_q,
  input logic          err_flag,
  input logic          irq
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_gnt |=> m_req && $stable(m_addr));
  a_r3_miss_served_by_refill: assert property (@(posedge clk) disable iff (!rst_n)
    f_ready && f_req && !f_we && !hit_any |-> refill_act);
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable && f_req && f_we |=> err_flag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_flag);
  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !(f_ready && !f_we));
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable |=> $stable(mode_q));
endmodule

bind icache icache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .f_req(f_req), .f_we(f_we), .f_ready(f_ready),
  .hit_any(hit), .refill_act(refill_act), .m_req(m_req), .m_gnt(m_gnt),
  .m_addr(m_addr), .inv_busy(inv_busy), .cfg_enable(cfg_enable),
  .mode_q(mode_q), .err_flag(err_flag), .irq(irq)
);

// File: tb/icache_tb_top.sv
module icache_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_enable = 1, cfg_direct = 0, inv_req = 0, err_irq_en = 0, err_clear = 0;
  logic f_req = 0, f_we = 0;
  logic [31:0] f_addr = 0;
  logic m_gnt, m_rvalid;
  logic [31:0] m_rdata;
  wire inv_busy, err_flag, irq, f_ready, m_req;
  wire [31:0] f_rdata, m_addr;

  always #5 clk = ~clk;

  icache dut_i (.*);

  int total = 0, bad = 0, grants = 0;
  bit mem_busy = 0, last_fwd, last_busy;
  int last_waits;
  int lines [32][$];
  bit mdl_en = 1, mdl_direct = 0;

  function automatic logic [31:0] memf(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_0000;
  endfunction

  task automatic chk(string tg, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  function automatic bit model(logic [31:0] a);
    int ln = int'(a >> 4);
    int s = ln % 32;
    if (!mdl_en) return 0;
    foreach (lines[s][i]) if (lines[s][i] == ln) begin
      lines[s].delete(i);
      lines[s].push_front(ln);
      return 1;
    end
    lines[s].push_front(ln);
    if (lines[s].size() > (mdl_direct ? 1 : 2)) void'(lines[s].pop_back());
    return 0;
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < 32; s++) lines[s].delete();
  endfunction

  initial begin
    m_gnt = 0; m_rvalid = 0; m_rdata = 0;
    forever begin
      @(negedge clk);
      if (m_req) begin
        logic [31:0] ga;
        ga = m_addr;
        m_gnt = 1; grants++; mem_busy = 1;
        @(negedge clk); m_gnt = 0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          m_rvalid = 1;
          m_rdata = memf({ga[31:4], 2'(ga[3:2] + k), 2'b00});
          @(negedge clk);
        end
        m_rvalid = 0; mem_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && f_req && f_ready && !f_we) chk("R1/R3/R5 data", int'(f_rdata), int'(memf(f_addr)));
  end

  task automatic drain();
    do #3; while (mem_busy || m_req || inv_busy) ;
    @(negedge clk);
  endtask

  task automatic fetch(logic [31:0] a, bit we, bit c, string tg, bit dr);
    bit exp = 0;
    int w = 0;
    if (!we) exp = model(a);
    f_req = 1; f_we = we; f_addr = a;
    forever begin
      #1;
      if (f_ready) break;
      w++;
      @(negedge clk);
    end
    last_fwd = m_rvalid; last_busy = mem_busy; last_waits = w;
    @(negedge clk); f_req = 0; f_we = 0;
    if (c) chk(tg, int'(w == 0), int'(exp));
    if (dr) drain();
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g, n;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 m_req", m_req, 0); chk("R12 inv_busy", inv_busy, 0);
    chk("R12 err_flag", err_flag, 0); chk("R12 irq", irq, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R12 f_ready idle", f_ready, 0);
    @(negedge clk);

    g = grants;
    f_req = 1; f_addr = 32'h1008; void'(model(32'h1008));
    @(negedge clk); #1;
    chk("R2 m_req", m_req, 1); chk("R2 m_addr", int'(m_addr), 32'h1008);
    forever begin if (f_ready) break; @(negedge clk); #1; end
    chk("R3 forwarded with beat", m_rvalid, 1);
    @(negedge clk); f_req = 0; drain();
    chk("R2 one burst", grants - g, 1);

    fetch(32'h1000, 0, 1, "R1 hit", 1);
    chk("R1 zero wait", last_waits, 0);

    g = grants;
    fetch(32'h3038, 0, 1, "R4 miss C", 0);
    chk("R3 critical word", int'(last_fwd), 1);
    fetch(32'h1004, 0, 1, "R4 hit under miss", 0);
    chk("R4 refill in flight", int'(last_busy), 1);
    fetch(32'h3034, 0, 0, "", 1);
    chk("R5 no second burst", grants - g, 1);
    chk("R5 waited for tail", int'(last_waits > 0), 1);

    fetch(32'h0050, 0, 1, "R6 P miss", 1);
    fetch(32'h1050, 0, 1, "R6 Q miss", 1);
    fetch(32'h0054, 0, 1, "R6 P hit", 1);
    fetch(32'h2050, 0, 1, "R6 R evicts Q", 1);
    fetch(32'h0058, 0, 1, "R6 P kept", 1);
    fetch(32'h105C, 0, 1, "R6 Q gone", 1);

    cfg_enable = 0; cfg_direct = 1;
    @(negedge clk); #1;
    chk("R10 mode change invalidates", inv_busy, 1);
    drain(); cfg_enable = 1; mdl_direct = 1; model_clear();
    fetch(32'h0050, 0, 1, "R7 P miss", 1);
    fetch(32'h1050, 0, 1, "R7 Q evicts P", 1);
    fetch(32'h0050, 0, 1, "R7 P miss again", 1);

    cfg_direct = 0;
    @(negedge clk); #1;
    chk("R10 ignored while enabled", inv_busy, 0);
    @(negedge clk);
    fetch(32'h1050, 0, 1, "R10 still direct Q", 1);
    fetch(32'h0050, 0, 1, "R10 still direct P", 1);
    cfg_enable = 0;
    @(negedge clk); drain();
    cfg_enable = 1; mdl_direct = 0; model_clear();

    fetch(32'h1008, 0, 1, "R9 fill", 1);
    fetch(32'h1008, 0, 1, "R9 hit before", 1);
    inv_req = 1;
    @(negedge clk); inv_req = 0; n = 0;
    #1;
    while (inv_busy) begin n++; @(negedge clk); #1; end
    chk("R9 busy cycles", n, 33);
    @(negedge clk);
    model_clear();
    fetch(32'h1008, 0, 1, "R9 miss after", 1);

    cfg_enable = 0; mdl_en = 0; g = grants;
    fetch(32'h1008, 0, 1, "R11 disabled miss", 1);
    fetch(32'h1008, 0, 1, "R11 no allocate", 1);
    chk("R11 bursts", grants - g, 2);
    cfg_enable = 1; mdl_en = 1;
    fetch(32'h100C, 0, 1, "R11 old line valid", 1);

    err_irq_en = 1; g = grants;
    fetch(32'h1008, 1, 0, "", 0);
    #1;
    chk("R8 accepted", last_waits, 0);
    chk("R8 flag", err_flag, 1); chk("R8 irq", irq, 1);
    chk("R8 no refill", grants - g, 0);
    err_clear = 1; @(negedge clk); err_clear = 0; #1;
    chk("R8 cleared", err_flag, 0);
    err_irq_en = 0;
    @(negedge clk);
    fetch(32'h1008, 1, 0, "", 0);
    #1;
    chk("R8 flag masked", err_flag, 1); chk("R8 irq masked", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule